// File: doc/BRIEF.md
# Operand-Capturing Wakeup/Select Issue Queue

This block sits between rename and the functional units of an out-of-order core. Each renamed instruction goes into a free slot of the queue. Each of its two source operands arrives in one of two forms. It is either a value that is already known, or the tag of the instruction that will produce it. A source that is still waiting watches the result buses, which carry a tag and a value. When a bus tag matches, the source copies the value and becomes ready. Because the value is held in the queue, an instruction leaves with everything it needs, and no register file is read at issue.

Each cycle the queue picks up to `ISSUE_W` slots whose two sources are both ready. Lower slot numbers win. The queue drives out the opcode, both operand values and the destination tag of each picked slot. A picked slot is released at the next clock edge and can take a new instruction. There is one result bus per issue slot. Dispatch accepts one instruction per cycle and puts it into the lowest-numbered free slot. When no slot is free, the queue raises `full` and ignores dispatch.

Top module: `opq_sched`

## Requirements
- R1: After synchronous reset, no issue slot is valid and `full` is low.
- R2: A dispatched instruction with both sources marked ready appears on issue output slot 0 in the cycle after the dispatch edge. It carries its opcode, its two values and its destination tag, provided no lower slot is also ready.
- R3: A source dispatched as not ready keeps its instruction from issuing until a valid result bus carries its tag. It is then ready from the next cycle, and its value is the one that bus carried.
- R4: Every result bus can wake a source, on either the left or the right operand. Bus b takes tag bits [b*TAG_W +: TAG_W] and value bits [b*32 +: 32].
- R5: If a result bus carries a source's tag in the same cycle that the instruction is dispatched, the capture still takes effect.
- R6: In each cycle, issue slot k (bits [k*W +: W] of each issue output) carries the k-th lowest-numbered ready queue slot. Slot k is valid only if slot k-1 is valid. At most `ISSUE_W` instructions issue per cycle.
- R7: A ready instruction that loses selection stays queued and issues in a later cycle.
- R8: A slot is released at the clock edge after its instruction issues, so `full` drops and the slot can be reused.
- R9: `full` is high exactly when all `NUM_ENT` slots are occupied. A dispatch while `full` is high is dropped and never issues.
- R10: A result bus with its valid bit low, or carrying a different tag, does not wake a waiting source.
- R11: A new instruction takes the lowest-numbered free slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_op | input | 8 | Opcode |
| disp_dst | input | 6 | Destination tag |
| disp_lrdy | input | 1 | Left source value is known |
| disp_ltag | input | 6 | Left source producer tag |
| disp_lval | input | 32 | Left source value |
| disp_rrdy | input | 1 | Right source value is known |
| disp_rtag | input | 6 | Right source producer tag |
| disp_rval | input | 32 | Right source value |
| full | output | 1 | No free slot, dispatch ignored |
| bc_valid | input | ISSUE_W | Result bus valid, one bit per bus |
| bc_tag | input | ISSUE_W*6 | Result bus tags, packed |
| bc_val | input | ISSUE_W*32 | Result bus values, packed |
| iss_valid | output | ISSUE_W | Issue slot valid |
| iss_op | output | ISSUE_W*8 | Issued opcodes |
| iss_lval | output | ISSUE_W*32 | Issued left operands |
| iss_rval | output | ISSUE_W*32 | Issued right operands |
| iss_dst | output | ISSUE_W*6 | Issued destination tags |

## Verification
The bench first sends eight instructions that are ready at dispatch, one at a time. Each one shows whether the opcode, both values and the destination tag pass through intact. It then sweeps every combination of result bus and operand side. Each of these instructions waits on one tag, is first shown a wrong tag and a masked bus, and is then shown the matching broadcast. This separates a real capture from a false wakeup and catches a bus or side that is wired wrong. A same-cycle dispatch and broadcast case covers the capture path on the write port. A full queue is then woken in selected patterns: two far-apart slots, three ready at once, and a fresh dispatch racing an old slot. These patterns expose errors in select order, retry, release and slot allocation.

// File: rtl/opq_pkg.sv
package opq_pkg;

    localparam int OPQ_DATA_W = 32;
    localparam int OPQ_TAG_W  = 6;
    localparam int OPQ_OP_W   = 8;

    typedef struct packed {
        logic                  rdy;
        logic [OPQ_TAG_W-1:0]  tag;
        logic [OPQ_DATA_W-1:0] val;
    } opnd_t;

    typedef struct packed {
        logic                  busy;
        logic [OPQ_OP_W-1:0]   op;
        logic [OPQ_TAG_W-1:0]  dst;
        opnd_t                 lsrc;
        opnd_t                 rsrc;
    } slot_t;

    // Snoop one result bus: a waiting operand with a matching tag takes the value.
    function automatic opnd_t snoop(opnd_t s, logic hit_v,
                                    logic [OPQ_TAG_W-1:0] t,
                                    logic [OPQ_DATA_W-1:0] v);
        opnd_t r;
        r = s;
        if (!s.rdy && hit_v && (t == s.tag)) begin
            r.rdy = 1'b1;
            r.val = v;
        end
        return r;
    endfunction

endpackage

// File: rtl/opq_entry.sv
module opq_entry
    import opq_pkg::*;
#(
    parameter int ISSUE_W = 2
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 wr_en,
    input  slot_t                                wr_slot,
    input  logic                                 grant,
    input  logic [ISSUE_W-1:0]                   bc_vld,
    input  logic [ISSUE_W-1:0][OPQ_TAG_W-1:0]    bc_tag,
    input  logic [ISSUE_W-1:0][OPQ_DATA_W-1:0]   bc_val,
    output slot_t                                cur,
    output logic                                 bid
);

    slot_t cur_q;
    slot_t nxt;

    always_comb begin
        nxt = cur_q;
        if (wr_en) begin
            nxt      = wr_slot;
            nxt.busy = 1'b1;
        end else if (grant) begin
            nxt.busy = 1'b0;
        end
        // Wakeup applies to freshly written contents too, so no broadcast is missed.
        for (int b = 0; b < ISSUE_W; b++) begin
            nxt.lsrc = snoop(nxt.lsrc, bc_vld[b] && nxt.busy, bc_tag[b], bc_val[b]);
            nxt.rsrc = snoop(nxt.rsrc, bc_vld[b] && nxt.busy, bc_tag[b], bc_val[b]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '0;
        else     cur_q <= nxt;
    end

    assign cur = cur_q;
    assign bid = cur_q.busy && cur_q.lsrc.rdy && cur_q.rsrc.rdy;

endmodule

// File: rtl/opq_alloc.sv
module opq_alloc #(
    parameter int NUM_ENT = 8
) (
    input  logic [NUM_ENT-1:0] busy,
    output logic [NUM_ENT-1:0] pick,
    output logic               full
);

    logic found;

    always_comb begin
        pick  = '0;
        found = 1'b0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (!found && !busy[i]) begin
                pick[i] = 1'b1;
                found   = 1'b1;
            end
        end
    end

    assign full = &busy;

endmodule

// File: rtl/opq_pick.sv
module opq_pick #(
    parameter int NUM_ENT = 8,
    parameter int ISSUE_W = 2,
    localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic [NUM_ENT-1:0]             bid,
    output logic [NUM_ENT-1:0]             gnt,
    output logic [ISSUE_W-1:0]             sl_vld,
    output logic [ISSUE_W-1:0][IDX_W-1:0]  sl_idx
);

    logic [NUM_ENT-1:0] remain;

    always_comb begin
        remain = bid;
        gnt    = '0;
        sl_vld = '0;
        sl_idx = '0;
        for (int k = 0; k < ISSUE_W; k++) begin
            for (int i = 0; i < NUM_ENT; i++) begin
                if (!sl_vld[k] && remain[i]) begin
                    sl_vld[k] = 1'b1;
                    sl_idx[k] = IDX_W'(i);
                end
            end
            if (sl_vld[k]) begin
                remain[sl_idx[k]] = 1'b0;
                gnt[sl_idx[k]]    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/opq_sched.sv
module opq_sched
    import opq_pkg::*;
#(
    parameter int NUM_ENT = 8,
    parameter int ISSUE_W = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          disp_valid,
    input  logic [OPQ_OP_W-1:0]           disp_op,
    input  logic [OPQ_TAG_W-1:0]          disp_dst,
    input  logic                          disp_lrdy,
    input  logic [OPQ_TAG_W-1:0]          disp_ltag,
    input  logic [OPQ_DATA_W-1:0]         disp_lval,
    input  logic                          disp_rrdy,
    input  logic [OPQ_TAG_W-1:0]          disp_rtag,
    input  logic [OPQ_DATA_W-1:0]         disp_rval,
    output logic                          full,
    input  logic [ISSUE_W-1:0]            bc_valid,
    input  logic [ISSUE_W*OPQ_TAG_W-1:0]  bc_tag,
    input  logic [ISSUE_W*OPQ_DATA_W-1:0] bc_val,
    output logic [ISSUE_W-1:0]            iss_valid,
    output logic [ISSUE_W*OPQ_OP_W-1:0]   iss_op,
    output logic [ISSUE_W*OPQ_DATA_W-1:0] iss_lval,
    output logic [ISSUE_W*OPQ_DATA_W-1:0] iss_rval,
    output logic [ISSUE_W*OPQ_TAG_W-1:0]  iss_dst
);

    localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

    logic [ISSUE_W-1:0][OPQ_TAG_W-1:0]  bc_tag_a;
    logic [ISSUE_W-1:0][OPQ_DATA_W-1:0] bc_val_a;
    slot_t [NUM_ENT-1:0]                ent_q;
    logic  [NUM_ENT-1:0]                busy;
    logic  [NUM_ENT-1:0]                bid;
    logic  [NUM_ENT-1:0]                gnt;
    logic  [NUM_ENT-1:0]                pick;
    logic  [ISSUE_W-1:0]                sl_vld;
    logic  [ISSUE_W-1:0][IDX_W-1:0]     sl_idx;
    slot_t                              wr_slot;
    logic                               accept;

    for (genvar b = 0; b < ISSUE_W; b++) begin : g_bus
        assign bc_tag_a[b] = bc_tag[b*OPQ_TAG_W +: OPQ_TAG_W];
        assign bc_val_a[b] = bc_val[b*OPQ_DATA_W +: OPQ_DATA_W];
    end

    always_comb begin
        wr_slot          = '0;
        wr_slot.busy     = 1'b1;
        wr_slot.op       = disp_op;
        wr_slot.dst      = disp_dst;
        wr_slot.lsrc.rdy = disp_lrdy;
        wr_slot.lsrc.tag = disp_ltag;
        wr_slot.lsrc.val = disp_lval;
        wr_slot.rsrc.rdy = disp_rrdy;
        wr_slot.rsrc.tag = disp_rtag;
        wr_slot.rsrc.val = disp_rval;
    end

    assign accept = disp_valid && !full;

    opq_alloc #(.NUM_ENT(NUM_ENT)) u_alloc (
        .busy (busy),
        .pick (pick),
        .full (full)
    );

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
        opq_entry #(.ISSUE_W(ISSUE_W)) u_ent (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (accept && pick[e]),
            .wr_slot (wr_slot),
            .grant   (gnt[e]),
            .bc_vld  (bc_valid),
            .bc_tag  (bc_tag_a),
            .bc_val  (bc_val_a),
            .cur     (ent_q[e]),
            .bid     (bid[e])
        );
        assign busy[e] = ent_q[e].busy;
    end

    opq_pick #(.NUM_ENT(NUM_ENT), .ISSUE_W(ISSUE_W)) u_pick (
        .bid    (bid),
        .gnt    (gnt),
        .sl_vld (sl_vld),
        .sl_idx (sl_idx)
    );

    for (genvar k = 0; k < ISSUE_W; k++) begin : g_out
        slot_t chosen;
        assign chosen       = ent_q[sl_idx[k]];
        assign iss_valid[k] = sl_vld[k];
        assign iss_op  [k*OPQ_OP_W   +: OPQ_OP_W]   = chosen.op;
        assign iss_lval[k*OPQ_DATA_W +: OPQ_DATA_W] = chosen.lsrc.val;
        assign iss_rval[k*OPQ_DATA_W +: OPQ_DATA_W] = chosen.rsrc.val;
        assign iss_dst [k*OPQ_TAG_W  +: OPQ_TAG_W]  = chosen.dst;
    end

endmodule

// File: rtl/opq_sched_chk.sv
module opq_sched_chk
    import opq_pkg::*;
#(
    parameter int NUM_ENT = 8,
    parameter int ISSUE_W = 2
) (
    input logic                                clk,
    input logic                                rst,
    input logic                                full,
    input logic [ISSUE_W-1:0]                  iss_valid,
    input slot_t [NUM_ENT-1:0]                 ent_q,
    input logic [NUM_ENT-1:0]                  bid,
    input logic [NUM_ENT-1:0]                  gnt,
    input logic [ISSUE_W-1:0]                  bc_vld,
    input logic [ISSUE_W-1:0][OPQ_TAG_W-1:0]   bc_tag_a
);

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (iss_valid == '0) && !full); // R1

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (full && (gnt == '0)) |=> full); // R9

    for (genvar k = 1; k < ISSUE_W; k++) begin : g_slot
        AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (rst)
            iss_valid[k] |-> iss_valid[k-1]); // R6
    end

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_e
        localparam logic [NUM_ENT-1:0] BELOW = (NUM_ENT'(1) << e) - NUM_ENT'(1);

        AST_GRANT_READY: assert property (@(posedge clk) disable iff (rst)
            gnt[e] |-> (ent_q[e].busy && ent_q[e].lsrc.rdy && ent_q[e].rsrc.rdy)); // R3

        AST_GRANT_PRIORITY: assert property (@(posedge clk) disable iff (rst)
            gnt[e] |-> ($countones(bid & ~gnt & BELOW) == 0)); // R6

        AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
            gnt[e] |=> !ent_q[e].busy); // R8

        AST_KEEP_BIDDING: assert property (@(posedge clk) disable iff (rst)
            (bid[e] && !gnt[e]) |=> bid[e]); // R7

        for (genvar b = 0; b < ISSUE_W; b++) begin : g_b
            AST_WAKE_LEFT: assert property (@(posedge clk) disable iff (rst)
                (ent_q[e].busy && !ent_q[e].lsrc.rdy && bc_vld[b] &&
                 (bc_tag_a[b] == ent_q[e].lsrc.tag)) |=> ent_q[e].lsrc.rdy); // R4
        end
    end

endmodule

bind opq_sched opq_sched_chk #(.NUM_ENT(NUM_ENT), .ISSUE_W(ISSUE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .full      (full),
    .iss_valid (iss_valid),
    .ent_q     (ent_q),
    .bid       (bid),
    .gnt       (gnt),
    .bc_vld    (bc_valid),
    .bc_tag_a  (bc_tag_a)
);

// File: tb/sim_opq_sched.sv
module sim_opq_sched;
    import opq_pkg::*;

    localparam int NE = 8;
    localparam int IW = 2;
    localparam int DW = OPQ_DATA_W;
    localparam int TW = OPQ_TAG_W;
    localparam int OW = OPQ_OP_W;

    logic clk = 1'b0;
    logic rst;
    logic disp_valid;
    logic [OW-1:0] disp_op;
    logic [TW-1:0] disp_dst, disp_ltag, disp_rtag;
    logic disp_lrdy, disp_rrdy;
    logic [DW-1:0] disp_lval, disp_rval;
    logic full;
    logic [IW-1:0] bc_valid;
    logic [IW*TW-1:0] bc_tag;
    logic [IW*DW-1:0] bc_val;
    logic [IW-1:0] iss_valid;
    logic [IW*OW-1:0] iss_op;
    logic [IW*DW-1:0] iss_lval, iss_rval;
    logic [IW*TW-1:0] iss_dst;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    opq_sched #(.NUM_ENT(NE), .ISSUE_W(IW)) u0 (
        .clk(clk), .rst(rst), .disp_valid(disp_valid), .disp_op(disp_op),
        .disp_dst(disp_dst), .disp_lrdy(disp_lrdy), .disp_ltag(disp_ltag),
        .disp_lval(disp_lval), .disp_rrdy(disp_rrdy), .disp_rtag(disp_rtag),
        .disp_rval(disp_rval), .full(full), .bc_valid(bc_valid), .bc_tag(bc_tag),
        .bc_val(bc_val), .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_lval(iss_lval), .iss_rval(iss_rval), .iss_dst(iss_dst)
    );

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_in();
        disp_valid = 0; disp_op = '0; disp_dst = '0;
        disp_lrdy = 0; disp_ltag = '0; disp_lval = '0;
        disp_rrdy = 0; disp_rtag = '0; disp_rval = '0;
        bc_valid = '0; bc_tag = '0; bc_val = '0;
    endtask

    task automatic put(logic [OW-1:0] op, logic [TW-1:0] dst,
                       logic lr, logic [TW-1:0] lt, logic [DW-1:0] lv,
                       logic rr, logic [TW-1:0] rt, logic [DW-1:0] rv);
        disp_valid = 1; disp_op = op; disp_dst = dst;
        disp_lrdy = lr; disp_ltag = lt; disp_lval = lv;
        disp_rrdy = rr; disp_rtag = rt; disp_rval = rv;
    endtask

    task automatic bcast(int b, logic [TW-1:0] t, logic [DW-1:0] v);
        bc_valid[b] = 1'b1;
        bc_tag[b*TW +: TW] = t;
        bc_val[b*DW +: DW] = v;
    endtask

    task automatic exp_slot(int k, logic [OW-1:0] op, logic [DW-1:0] lv,
                            logic [DW-1:0] rv, logic [TW-1:0] dst, string req);
        check(req, $sformatf("slot%0d valid", k), 64'(iss_valid[k]), 64'd1);
        check(req, $sformatf("slot%0d op", k), 64'(iss_op[k*OW +: OW]), 64'(op));
        check(req, $sformatf("slot%0d lval", k), 64'(iss_lval[k*DW +: DW]), 64'(lv));
        check(req, $sformatf("slot%0d rval", k), 64'(iss_rval[k*DW +: DW]), 64'(rv));
        check(req, $sformatf("slot%0d dst", k), 64'(iss_dst[k*TW +: TW]), 64'(dst));
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        idle_in();
        rst = 1;
        repeat (3) tick();
        rst = 0;
        // R1: reset state
        check("R1", "iss_valid", 64'(iss_valid), 64'd0);
        check("R1", "full", 64'(full), 64'd0);
        tick();
        check("R1", "iss_valid idle", 64'(iss_valid), 64'd0);

        // R2/R8: ready-at-dispatch sweep
        for (int i = 0; i < 8; i++) begin
            logic [DW-1:0] lv, rv;
            lv = DW'(32'h1000 * i + 7);
            rv = ~DW'(i * 5);
            put(OW'(8'h10 + i), TW'(i), 1, '0, lv, 1, '0, rv);
            tick();
            idle_in();
            exp_slot(0, OW'(8'h10 + i), lv, rv, TW'(i), "R2");
            check("R2", "slot1 idle", 64'(iss_valid[1]), 64'd0);
            tick();
            check("R8", "released", 64'(iss_valid), 64'd0);
            check("R8", "full", 64'(full), 64'd0);
        end

        // R3/R4/R10: each bus, each operand side
        for (int b = 0; b < IW; b++) begin
            for (int s = 0; s < 2; s++) begin
                logic [TW-1:0] t;
                logic [DW-1:0] v;
                t = TW'(10 + 2 * b + s);
                v = DW'(32'hA000_0000 + b * 16 + s);
                if (s == 0) put(8'h20, 6'd33, 0, t, '0, 1, '0, 32'd5);
                else        put(8'h20, 6'd33, 1, '0, 32'd5, 0, t, '0);
                tick();
                idle_in();
                check("R3", "waiting not issued", 64'(iss_valid), 64'd0);
                bcast(b, t + 6'd1, 32'd1);
                bcast(1 - b, t, 32'd2);
                bc_valid[1 - b] = 1'b0;
                tick();
                idle_in();
                check("R10", "no false wake", 64'(iss_valid), 64'd0);
                bcast(b, t, v);
                tick();
                idle_in();
                if (s == 0) exp_slot(0, 8'h20, v, 32'd5, 6'd33, "R4");
                else        exp_slot(0, 8'h20, 32'd5, v, 6'd33, "R4");
                tick();
                check("R3", "drained", 64'(iss_valid), 64'd0);
            end
        end

        // R5: broadcast in the dispatch cycle
        put(8'h30, 6'd40, 0, 6'd20, '0, 0, 6'd21, '0);
        bcast(0, 6'd21, 32'hCAFE_0001);
        bcast(1, 6'd20, 32'hCAFE_0002);
        tick();
        idle_in();
        exp_slot(0, 8'h30, 32'hCAFE_0002, 32'hCAFE_0001, 6'd40, "R5");
        tick();

        // Fill: slot i waits on tag 30+i
        for (int i = 0; i < NE; i++) begin
            put(OW'(8'h40 + i), TW'(i), 0, TW'(30 + i), '0, 1, '0, DW'(i));
            tick();
            idle_in();
        end
        check("R9", "full after fill", 64'(full), 64'd1);
        put(8'hEE, 6'd1, 1, '0, 32'd9, 1, '0, 32'd9);
        tick();
        idle_in();
        check("R9", "dropped dispatch", 64'(iss_valid), 64'd0);
        check("R9", "still full", 64'(full), 64'd1);

        // R6: wake slots 5 and 2, slot 2 must lead
        bcast(0, 6'd35, 32'h55);
        bcast(1, 6'd32, 32'h22);
        tick();
        idle_in();
        exp_slot(0, 8'h42, 32'h22, 32'd2, 6'd2, "R6");
        exp_slot(1, 8'h45, 32'h55, 32'd5, 6'd5, "R6");
        tick();
        check("R8", "full drops", 64'(full), 64'd0);
        check("R8", "no issue", 64'(iss_valid), 64'd0);

        // R7: three ready at once (slots 0,1 woken, new ready one into slot 2)
        put(8'h52, 6'd12, 1, '0, 32'h77, 1, '0, 32'h88);
        bcast(0, 6'd30, 32'h300);
        bcast(1, 6'd31, 32'h310);
        tick();
        idle_in();
        exp_slot(0, 8'h40, 32'h300, 32'd0, 6'd0, "R6");
        exp_slot(1, 8'h41, 32'h310, 32'd1, 6'd1, "R6");
        tick();
        exp_slot(0, 8'h52, 32'h77, 32'h88, 6'd12, "R7");
        check("R7", "slot1 idle", 64'(iss_valid[1]), 64'd0);
        tick();

        // R11: new instruction must take slot 0, ahead of woken slot 3
        put(8'h60, 6'd20, 1, '0, 32'h6, 1, '0, 32'h7);
        bcast(0, 6'd33, 32'h333);
        tick();
        idle_in();
        exp_slot(0, 8'h60, 32'h6, 32'h7, 6'd20, "R11");
        exp_slot(1, 8'h43, 32'h333, 32'd3, 6'd3, "R11");
        tick();

        // Drain remaining slots 4,6,7
        bcast(0, 6'd34, 32'h444);
        bcast(1, 6'd36, 32'h666);
        tick();
        idle_in();
        exp_slot(0, 8'h44, 32'h444, 32'd4, 6'd4, "R6");
        exp_slot(1, 8'h46, 32'h666, 32'd6, 6'd6, "R6");
        bcast(1, 6'd37, 32'h777);
        tick();
        idle_in();
        exp_slot(0, 8'h47, 32'h777, 32'd7, 6'd7, "R4");
        tick();
        check("R9", "empty not full", 64'(full), 64'd0);
        check("R9", "dropped never issued", 64'(iss_valid), 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule